// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Bus

This block is a target on a two-wire, open-drain serial bus, the SMBus/I2C kind. It gives a host access to eight one-byte control and status registers. A fast system clock oversamples the bus lines, and the target pulls the data line low through an output-enable. It never drives the line high. At the first rising edge of the power-good input, a three-level strap is sampled. That sample fixes the target's 7-bit address, and the address stays fixed until reset.

A host writes in one indexed block transfer. After the address byte it sends a starting index, then a count, then that many data bytes. The data bytes land at consecutive indices. To read, the host first writes only the index. It then issues a repeated start and addresses the target for reading. The target answers with a count byte taken from its own length register, then sends data from the index upward for as long as the host acknowledges.

The writable fields drive the block's outputs: seven output enables, a two-bit amplitude code and seven slew selects. Identification bytes and reserved bits return fixed values.

Top module: `smbr_target`

## Requirements
- R1: On the first rising edge of `pwr_good` after reset, the strap sets the address: low (`strap_lvl`=00) gives 0x6B, mid (01) gives 0x6C, high (10) gives 0x6D. Later power-good edges and later strap changes do not alter it.
- R2: Until that first power-good edge, the target acknowledges nothing and never asserts `sda_oe`.
- R3: The target acknowledges a byte that carries its own address and releases the line for any other address.
- R4: A block write works as follows. The host sends address+0, an index n, a count X, then data. Each of these bytes is acknowledged, and the data bytes are stored at n, n+1, and so on.
- R5: Once X data bytes have been stored, any further data byte is not acknowledged and is not stored.
- R6: A block read works as follows. The host sends address+0 and index n, then a repeated start and address+1. The target then sends {000, count} followed by the bytes at n, n+1, and so on, while the host acknowledges. After the host's NACK the line is released.
- R7: After reset, the register bytes 0..7 read FF, 6E, FF, C7, FF, 01, C7, 08. The ports are then `out_en`=7F, `amp_sel`=10 and `slew_fast`=7F.
- R8: Bits that read as constants cannot be written. These are bits 5 and 1 of bytes 0 and 2 (reading 1), bits 7, 6, 4, 3, 2 of byte 1 (reading 0, 1, 0, 1, 1), bits 7:1 of byte 3 (reading 1100011), and all of bytes 4, 5 and 6 (FF, 01, C7).
- R9: Byte 7 bits 4:0 hold the read-back count and are writable. Byte 7 bits 7:5 always read 0.
- R10: An index above 7 reads as 0x00, and a write to it changes nothing.
- R11: A stop or a start in the middle of a transfer ends it and sends the target back to waiting for an address. Bytes that were already completed stay stored.
- R12: The register bits map to ports as follows. Byte 0 bits 7, 6, 4, 3, 2, 0 drive `out_en`[5:0] and byte 1 bit 5 drives `out_en`[6]. Byte 1 bits 1:0 drive `amp_sel`. Byte 2, using the same bit positions as byte 0, drives `slew_fast`[5:0], and byte 3 bit 0 drives `slew_fast`[6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Power-good; its first rise latches the address strap |
| strap_lvl | input | 2 | Three-level strap code: 00 low, 01 mid, 10 high |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When high, pull the data line low |
| out_en | output | 7 | Per-output enable bits |
| amp_sel | output | 2 | Amplitude code (00 0.6 V to 11 0.9 V) |
| slew_fast | output | 7 | Per-output slew select, 1 = fast |

## Verification
The hardest condition to reach is a transfer cut off partway through a byte. The target must drop the partial byte and keep every byte it had already completed. The stimulus creates this in two ways. In the first, a block write commits one data byte and then gets a stop after four bits of the next byte. In the second, a start arrives in the middle of the count byte. After each, the bench reads the ports and the register bytes back through a normal block read. These show that the first byte took effect, the second did not, and the bus still answers.

// File: rtl/smbr_pkg.sv
`timescale 1ns/1ps
package smbr_pkg;
    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam int NOUT   = 7;
    localparam int BC_W   = 5;

    typedef enum logic [2:0] {L_IDLE, L_RX, L_ACK, L_TX, L_TXACK, L_WAIT} link_e;
    typedef enum logic [1:0] {PH_ADDR, PH_IDX, PH_CNT, PH_DATA} phase_e;

    typedef struct packed {
        logic [NOUT-1:0] oe;
        logic [1:0]      amp;
        logic [NOUT-1:0] slew;
        logic [BC_W-1:0] cnt;
    } cfg_t;

    localparam cfg_t CFG_RST = '{oe: 7'h7F, amp: 2'b10, slew: 7'h7F, cnt: 5'd8};

    function automatic logic [6:0] strap_addr(input logic [1:0] lvl);
        case (lvl)
            2'b00:   return 7'h6B;
            2'b10:   return 7'h6D;
            default: return 7'h6C;
        endcase
    endfunction

    // six per-output bits spread over a byte, bits 5 and 1 fixed at 1
    function automatic logic [7:0] pack6(input logic [5:0] v);
        return {v[5], v[4], 1'b1, v[3], v[2], v[1], 1'b1, v[0]};
    endfunction

    function automatic logic [5:0] unpack6(input logic [7:0] b);
        return {b[7], b[6], b[4], b[3], b[2], b[0]};
    endfunction

    function automatic logic [7:0] rd_byte(input cfg_t c, input logic [7:0] idx);
        case (idx)
            8'd0:    return pack6(c.oe[5:0]);
            8'd1:    return {2'b01, c.oe[6], 3'b011, c.amp};
            8'd2:    return pack6(c.slew[5:0]);
            8'd3:    return {7'b1100011, c.slew[6]};
            8'd4:    return 8'hFF;
            8'd5:    return 8'h01;
            8'd6:    return 8'hC7;
            8'd7:    return {{(BYTE_W-BC_W){1'b0}}, c.cnt};
            default: return 8'h00;
        endcase
    endfunction

    function automatic cfg_t apply_wr(input cfg_t c, input logic [7:0] idx, input logic [7:0] d);
        cfg_t n = c;
        case (idx)
            8'd0: n.oe[5:0]   = unpack6(d);
            8'd1: begin n.oe[6] = d[5]; n.amp = d[1:0]; end
            8'd2: n.slew[5:0] = unpack6(d);
            8'd3: n.slew[6]   = d[0];
            8'd7: n.cnt       = d[BC_W-1:0];
            default: ;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/smbr_sync.sv
`timescale 1ns/1ps
module smbr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= {STAGES{RST_VAL}};
        else     pipe <= {pipe[STAGES-2:0], raw};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/smbr_regfile.sv
`timescale 1ns/1ps
module smbr_regfile
    import smbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_idx,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_idx,
    output logic [7:0] rd_data,
    output cfg_t       cfg
);
    always_ff @(posedge clk) begin
        if (rst)        cfg <= CFG_RST;
        else if (wr_en) cfg <= apply_wr(cfg, wr_idx, wr_data);
    end

    assign rd_data = rd_byte(cfg, rd_idx);
endmodule

// File: rtl/smbr_link.sv
`timescale 1ns/1ps
module smbr_link
    import smbr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    input  logic [6:0]      my_addr,
    input  logic            sda_s,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_det,
    input  logic            stop_det,
    input  logic [BC_W-1:0] bc,
    input  logic [7:0]      rd_data,
    output logic [7:0]      idx,
    output logic            wr_en,
    output logic [7:0]      wr_idx,
    output logic [7:0]      wr_data,
    output logic            sda_oe
);
    link_e            st;
    phase_e           ph;
    logic [BIT_W-1:0] bitc;
    logic [7:0]       sh;
    logic [7:0]       left;
    logic             rw, done, acked;
    logic [7:0]       cnt_byte;

    assign cnt_byte = {{(BYTE_W-BC_W){1'b0}}, bc};

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= L_IDLE; ph <= PH_ADDR; bitc <= '0; sh <= '0; left <= '0;
            rw <= 1'b0; done <= 1'b0; acked <= 1'b0; idx <= '0;
            wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0; sda_oe <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (!enable) begin
                st <= L_IDLE; sda_oe <= 1'b0;
            end else if (start_det) begin
                st <= L_RX; ph <= PH_ADDR; bitc <= '0; done <= 1'b0; sda_oe <= 1'b0;
            end else if (stop_det) begin
                st <= L_IDLE; sda_oe <= 1'b0;
            end else begin
                case (st)
                    L_RX: begin
                        if (scl_rise) begin
                            sh   <= {sh[6:0], sda_s};
                            bitc <= bitc + 1'b1;
                            if (bitc == BIT_W'(BYTE_W-1)) done <= 1'b1;
                        end else if (scl_fall && done) begin
                            done <= 1'b0;
                            bitc <= '0;
                            st   <= L_ACK;
                            sda_oe <= 1'b1;
                            case (ph)
                                PH_ADDR: begin
                                    if (sh[7:1] == my_addr) begin
                                        rw <= sh[0];
                                        ph <= PH_IDX;
                                    end else begin
                                        st <= L_WAIT; sda_oe <= 1'b0;
                                    end
                                end
                                PH_IDX: begin idx <= sh; ph <= PH_CNT; end
                                PH_CNT: begin left <= sh; ph <= PH_DATA; end
                                default: begin
                                    if (left != 8'd0) begin
                                        wr_en <= 1'b1; wr_idx <= idx; wr_data <= sh;
                                        idx <= idx + 1'b1; left <= left - 1'b1;
                                    end else begin
                                        st <= L_WAIT; sda_oe <= 1'b0;
                                    end
                                end
                            endcase
                        end
                    end
                    L_ACK: if (scl_fall) begin
                        if (rw) begin
                            st <= L_TX; sh <= cnt_byte; sda_oe <= ~cnt_byte[7];
                        end else begin
                            st <= L_RX; sda_oe <= 1'b0;
                        end
                    end
                    L_TX: if (scl_fall) begin
                        if (bitc == BIT_W'(BYTE_W-1)) begin
                            bitc <= '0; sda_oe <= 1'b0; st <= L_TXACK;
                        end else begin
                            sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6]; bitc <= bitc + 1'b1;
                        end
                    end
                    L_TXACK: begin
                        if (scl_rise) acked <= ~sda_s;
                        else if (scl_fall) begin
                            if (acked) begin
                                sh <= rd_data; sda_oe <= ~rd_data[7];
                                idx <= idx + 1'b1; st <= L_TX;
                            end else begin
                                st <= L_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/smbr_target.sv
`timescale 1ns/1ps
module smbr_target
    import smbr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pwr_good,
    input  logic [1:0]      strap_lvl,
    input  logic            scl_in,
    input  logic            sda_in,
    output logic            sda_oe,
    output logic [NOUT-1:0] out_en,
    output logic [1:0]      amp_sel,
    output logic [NOUT-1:0] slew_fast
);
    logic scl_s, sda_s, pg_s, scl_p, sda_p, pg_p;
    logic strap_taken;
    logic [6:0] tgt_addr;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic reg_we;
    logic [7:0] reg_idx, wr_idx, wr_data, rd_data;
    cfg_t cfg;

    smbr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl (.clk(clk), .rst(rst), .raw(scl_in),   .q(scl_s));
    smbr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda (.clk(clk), .rst(rst), .raw(sda_in),   .q(sda_s));
    smbr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pg  (.clk(clk), .rst(rst), .raw(pwr_good), .q(pg_s));

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1; sda_p <= 1'b1; pg_p <= 1'b0;
            strap_taken <= 1'b0; tgt_addr <= '0;
        end else begin
            scl_p <= scl_s; sda_p <= sda_s; pg_p <= pg_s;
            if (pg_s && !pg_p && !strap_taken) begin
                strap_taken <= 1'b1;
                tgt_addr    <= strap_addr(strap_lvl);
            end
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

    smbr_link u_link (
        .clk(clk), .rst(rst), .enable(strap_taken), .my_addr(tgt_addr),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .bc(cfg.cnt),
        .rd_data(rd_data), .idx(reg_idx), .wr_en(reg_we),
        .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe)
    );

    smbr_regfile u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_we), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(reg_idx), .rd_data(rd_data), .cfg(cfg)
    );

    assign out_en    = cfg.oe;
    assign amp_sel   = cfg.amp;
    assign slew_fast = cfg.slew;
endmodule

// File: rtl/smbr_target_chk.sv
`timescale 1ns/1ps
module smbr_target_chk (
    input logic       clk,
    input logic       rst,
    input logic       taken,
    input logic [6:0] tgt_addr,
    input logic       sda_oe,
    input logic       stop_det,
    input logic       reg_we,
    input logic [6:0] out_en,
    input logic [1:0] amp_sel,
    input logic [6:0] slew_fast
);
    p_addr_fixed_r1: assert property (@(posedge clk) disable iff (rst)
        taken && $past(taken) |-> $stable(tgt_addr));

    p_silent_r2: assert property (@(posedge clk) disable iff (rst)
        !taken |-> !sda_oe);

    p_stop_release_r11: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

    p_defaults_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_en == 7'h7F && amp_sel == 2'b10 && slew_fast == 7'h7F));

    p_ports_on_write_r12: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(reg_we) |-> ($stable(out_en) && $stable(amp_sel) && $stable(slew_fast)));
endmodule

bind smbr_target smbr_target_chk u_chk (
    .clk(clk), .rst(rst), .taken(strap_taken), .tgt_addr(tgt_addr),
    .sda_oe(sda_oe), .stop_det(stop_det), .reg_we(reg_we),
    .out_en(out_en), .amp_sel(amp_sel), .slew_fast(slew_fast)
);

// File: tb/smbr_target_test.sv
`timescale 1ns/1ps
module smbr_target_test;
    logic       clk = 1'b0, rst = 1'b1, pwr_good = 1'b0;
    logic [1:0] strap_lvl = 2'b01;
    logic       scl_h = 1'b1, sda_h = 1'b1;
    logic       sda_oe;
    logic [6:0] out_en, slew_fast;
    logic [1:0] amp_sel;
    logic       sda_line;
    int         checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];
    localparam logic [6:0] MY = 7'h6C;

    assign sda_line = sda_h & ~sda_oe;
    always #2.5 clk = ~clk;

    smbr_target uut (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .strap_lvl(strap_lvl),
        .scl_in(scl_h), .sda_in(sda_line), .sda_oe(sda_oe),
        .out_en(out_en), .amp_sel(amp_sel), .slew_fast(slew_fast)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (got_q.size() != 0) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R6 unexpected byte actual=%0h expected=none", got_q.pop_front());
            end else begin
                chk(tag_q.pop_front(), 32'(got_q.pop_front()), 32'(exp_q.pop_front()));
            end
        end
    end

    task automatic expect_b(input string tag, input logic [7:0] v);
        exp_q.push_back(v); tag_q.push_back(tag);
    endtask

    task automatic q();        repeat (20) @(negedge clk); endtask
    task automatic bstart();   sda_h = 1; q(); scl_h = 1; q(); sda_h = 0; q(); scl_h = 0; q(); endtask
    task automatic bstop();    sda_h = 0; q(); scl_h = 1; q(); sda_h = 1; q(); endtask
    task automatic bbit(input logic b); sda_h = b; q(); scl_h = 1; q(); q(); scl_h = 0; q(); endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) bbit(d[i]);
        sda_h = 1; q(); scl_h = 1; q(); ack = ~sda_line; q(); scl_h = 0; q();
    endtask

    task automatic rbyte(input logic last, output logic [7:0] d);
        sda_h = 1;
        for (int i = 7; i >= 0; i--) begin
            q(); scl_h = 1; q(); d[i] = sda_line; q(); scl_h = 0;
        end
        q();
        bbit(last);
    endtask

    task automatic wr_blk(input string tag, input logic [7:0] n, input logic [7:0] cnt,
                          input logic [7:0] d [4], input int nd);
        logic ack;
        bstart();
        wbyte({MY, 1'b0}, ack); chk({tag, " addr ack"}, 32'(ack), 1);
        wbyte(n, ack);          chk({tag, " index ack"}, 32'(ack), 1);
        wbyte(cnt, ack);        chk({tag, " count ack"}, 32'(ack), 1);
        for (int i = 0; i < nd; i++) begin
            wbyte(d[i], ack);
            chk({tag, " data ack"}, 32'(ack), (i < int'(cnt)) ? 1 : 0);
        end
        bstop();
    endtask

    task automatic rd_blk(input string tag, input logic [7:0] n, input int nb);
        logic ack;
        logic [7:0] d;
        bstart();
        wbyte({MY, 1'b0}, ack); chk({tag, " wr addr ack"}, 32'(ack), 1);
        wbyte(n, ack);          chk({tag, " index ack"}, 32'(ack), 1);
        bstart();
        wbyte({MY, 1'b1}, ack); chk({tag, " rd addr ack"}, 32'(ack), 1);
        for (int i = 0; i < nb; i++) begin
            rbyte(i == nb - 1, d);
            got_q.push_back(d);
        end
        chk("R6 line released after NACK", 32'(sda_oe), 0);
        bstop();
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000 - 20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic ack;
        repeat (10) @(negedge clk);
        rst = 0;
        repeat (5) @(negedge clk);
        chk("R7 out_en reset", 32'(out_en), 32'h7F);
        chk("R7 amp_sel reset", 32'(amp_sel), 32'h2);
        chk("R7 slew_fast reset", 32'(slew_fast), 32'h7F);
        chk("R2 line idle", 32'(sda_oe), 0);

        // R2: no answer before power-good
        bstart(); wbyte({MY, 1'b0}, ack); chk("R2 no ack before power-good", 32'(ack), 0); bstop();

        // R1: mid strap latched, later edge with low strap ignored
        pwr_good = 1; q();
        strap_lvl = 2'b00; pwr_good = 0; q(); pwr_good = 1; q();
        bstart(); wbyte({7'h6B, 1'b0}, ack); chk("R1 R3 other address nack", 32'(ack), 0); bstop();

        // R6 R7: full default read
        expect_b("R6 count byte", 8'h08);
        expect_b("R7 byte0", 8'hFF); expect_b("R7 byte1", 8'h6E);
        expect_b("R7 byte2", 8'hFF); expect_b("R7 byte3", 8'hC7);
        expect_b("R7 byte4", 8'hFF); expect_b("R7 byte5", 8'h01);
        expect_b("R7 byte6", 8'hC7); expect_b("R7 byte7", 8'h08);
        rd_blk("R1 R6", 8'd0, 9);

        // R4 R12: clear enables and amplitude
        wr_blk("R4", 8'd0, 8'd2, '{8'h00, 8'h00, 8'h00, 8'h00}, 2);
        chk("R12 out_en", 32'(out_en), 0);
        chk("R12 amp_sel", 32'(amp_sel), 0);
        expect_b("R6 count", 8'h08); expect_b("R8 byte0 fixed bits", 8'h22);
        expect_b("R8 byte1 fixed bits", 8'h4C);
        rd_blk("R8", 8'd0, 3);

        // R8: read-only bytes ignore writes
        wr_blk("R8 ro", 8'd4, 8'd3, '{8'h00, 8'h00, 8'h00, 8'h00}, 3);
        expect_b("R6 count", 8'h08); expect_b("R8 byte4", 8'hFF);
        expect_b("R8 byte5", 8'h01); expect_b("R8 byte6", 8'hC7);
        rd_blk("R8", 8'd4, 4);

        // R9: count register
        wr_blk("R9", 8'd7, 8'd1, '{8'hE3, 8'h00, 8'h00, 8'h00}, 1);
        expect_b("R9 count byte", 8'h03); expect_b("R9 byte7 upper bits zero", 8'h03);
        rd_blk("R9", 8'd7, 2);

        // R12: slew bits
        wr_blk("R12 slew", 8'd2, 8'd2, '{8'hAA, 8'h00, 8'h00, 8'h00}, 2);
        chk("R12 slew_fast", 32'(slew_fast), 32'h24);

        // R11: stop inside the second data byte
        bstart();
        wbyte({MY, 1'b0}, ack); wbyte(8'd1, ack); wbyte(8'd2, ack);
        wbyte(8'h03, ack); chk("R11 first data ack", 32'(ack), 1);
        for (int i = 0; i < 4; i++) bbit(1'b1);
        bstop();
        chk("R11 committed amp_sel", 32'(amp_sel), 32'h3);
        chk("R11 committed out_en", 32'(out_en), 0);
        chk("R11 partial byte dropped", 32'(slew_fast), 32'h24);

        // R11: start inside the count byte, bus still answers
        bstart();
        wbyte({MY, 1'b0}, ack); wbyte(8'd2, ack);
        for (int i = 0; i < 3; i++) bbit(1'b0);
        expect_b("R11 count after abort", 8'h03);
        expect_b("R11 byte2", 8'hAA); expect_b("R11 byte3", 8'hC6);
        rd_blk("R11", 8'd2, 3);

        // R10: out-of-range index
        wr_blk("R10", 8'd9, 8'd1, '{8'h55, 8'h00, 8'h00, 8'h00}, 1);
        expect_b("R10 count", 8'h03); expect_b("R10 idx8", 8'h00); expect_b("R10 idx9", 8'h00);
        rd_blk("R10", 8'd8, 3);

        // R5: byte past the count
        wr_blk("R5", 8'd1, 8'd1, '{8'h20, 8'hFF, 8'h00, 8'h00}, 2);
        chk("R5 out_en after counted byte", 32'(out_en), 32'h40);
        chk("R5 amp_sel", 32'(amp_sel), 0);
        chk("R5 extra byte not stored", 32'(slew_fast), 32'h24);

        repeat (20) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R6 missing bytes actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end
endmodule